// File: doc/BRIEF.md
# Shortened RS(15,9) Parity Encoder

This block computes the six parity symbols of a Reed-Solomon (15,9) code with minimum distance 7. The code works over 4-bit symbols in GF(16), and its message is shortened to 32 bits. The host places a 32-bit message on `msg_in` and raises `en`. The block captures the word, then divides it serially by the generator polynomial, one symbol per cycle, through a six-stage feedback register with constant field multipliers. When the division finishes it drops `busy`, raises `ready` and presents the 24-bit remainder on `parity`. The host appends that remainder below the message to form a systematic codeword.

The field is built on the primitive polynomial x^4 + x + 1, with α = 2. The generator polynomial is the product of (x + α^i) for i = 1..6:

g(x) = x^6 + 7·x^5 + 9·x^4 + 3·x^3 + C·x^2 + A·x + C (hex symbol values).

The native 9-symbol message is shortened by a top symbol that is always zero. The division therefore sees, in order:

1. the implied zero symbol;
2. `msg_in[31:28]`;
3. each following nibble, down to `msg_in[3:0]`.

Top module: `rs15_parity_enc`

## Requirements
- R1: When `rst_n` is low, `busy`, `ready` and `parity` all go to zero. This holds even if reset arrives in the middle of a word.
- R2: A word is accepted at a rising clock edge where `en` is high and `busy` is low. After that edge `busy` is high and `ready` is low, whether or not `ready` was high before.
- R3: Once a word is accepted, `busy` stays high for exactly 9 cycles, one per message symbol including the implied zero symbol. `busy` falls and `ready` rises at the same edge, and the two are never high together.
- R4: `parity` equals the remainder of m(x)·x^6 divided by g(x), with m(x) formed from the implied zero symbol followed by the nibbles of `msg_in`, most significant first. For example, message 0x0002401C gives parity 0xC21CA6.
- R5: `parity[23:20]` holds the x^5 coefficient of the remainder and `parity[3:0]` holds the x^0 coefficient. So `{msg_in, parity}` is the 56-bit codeword, highest-degree symbol first.
- R6: While `ready` is high and no new word is accepted, `ready` stays high and `parity` does not change. This holds even if `msg_in` changes.
- R7: If `en` is low at an edge while `busy` is high, the word is abandoned: after that edge `busy` and `ready` are both low.
- R8: `msg_in` is sampled only at the accepting edge. Changes to `msg_in` while `busy` is high do not affect the resulting parity.
- R9: An all-zero message yields all-zero parity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Start request; must stay high until `ready` |
| msg_in | input | 32 | Message word, sampled at acceptance |
| busy | output | 1 | High while the division is in progress |
| ready | output | 1 | High when `parity` is valid for the last word |
| parity | output | 24 | Six parity symbols, x^5 coefficient on top |

## Verification
The properties assume the host follows the handshake. The host raises `en` only to start a word and keeps it high through the whole busy period, except when it deliberately abandons a word. After `ready` it lowers `en` before the next edge if it wants the result held. The stimulus obeys this in every run. The one exception is a single directed case that drops `en` three cycles into a word to exercise abandonment. All driving happens on falling edges, so each rising edge sees settled handshake inputs.

// File: rtl/rs15_parity_enc.sv
module rs15_parity_enc #(
  parameter int SYM_W = 4,
  parameter int K_SYM = 9,
  parameter int NPAR  = 6,
  parameter int MSG_W = 32,
  parameter int FCR   = 1,
  parameter logic [SYM_W:0] PRIM = 5'h13
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic [MSG_W-1:0]        msg_in,
  output logic                    busy,
  output logic                    ready,
  output logic [NPAR*SYM_W-1:0]   parity
);
  localparam int SR_W  = K_SYM * SYM_W;
  localparam int CNT_W = $clog2(K_SYM + 1);

  function automatic logic [SYM_W-1:0] gmul(input logic [SYM_W-1:0] a,
                                            input logic [SYM_W-1:0] b);
    logic [SYM_W-1:0] acc, sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < SYM_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = sh[SYM_W-1] ? ((sh << 1) ^ PRIM[SYM_W-1:0]) : (sh << 1);
    end
    return acc;
  endfunction

  function automatic logic [SYM_W-1:0] gpow(input int e);
    logic [SYM_W-1:0] r;
    r = SYM_W'(1);
    for (int i = 0; i < e; i++) r = gmul(r, SYM_W'(2));
    return r;
  endfunction

  function automatic logic [NPAR-1:0][SYM_W-1:0] gen_poly();
    logic [NPAR:0][SYM_W-1:0] c;
    logic [SYM_W-1:0] rt;
    c    = '0;
    c[0] = SYM_W'(1);
    for (int i = 0; i < NPAR; i++) begin
      rt = gpow(FCR + i);
      for (int j = NPAR; j > 0; j--) c[j] = c[j-1] ^ gmul(c[j], rt);
      c[0] = gmul(c[0], rt);
    end
    return c[NPAR-1:0];
  endfunction

  localparam logic [NPAR-1:0][SYM_W-1:0] GEN = gen_poly();

  logic [SR_W-1:0]              msg_sr;
  logic [NPAR-1:0][SYM_W-1:0]   par, par_nxt;
  logic [CNT_W-1:0]             cnt;
  logic [SYM_W-1:0]             fb;

  assign fb         = msg_sr[SR_W-1 -: SYM_W] ^ par[NPAR-1];
  assign par_nxt[0] = gmul(fb, GEN[0]);

  for (genvar i = 1; i < NPAR; i++) begin : g_stage
    assign par_nxt[i] = par[i-1] ^ gmul(fb, GEN[i]);
  end

  assign parity = par;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_sr <= '0;
      par    <= '0;
      cnt    <= '0;
      busy   <= 1'b0;
      ready  <= 1'b0;
    end else if (!busy) begin
      if (en) begin
        msg_sr <= SR_W'(msg_in);
        par    <= '0;
        cnt    <= '0;
        busy   <= 1'b1;
        ready  <= 1'b0;
      end
    end else if (!en) begin
      busy  <= 1'b0;
      ready <= 1'b0;
    end else begin
      par    <= par_nxt;
      msg_sr <= msg_sr << SYM_W;
      cnt    <= cnt + 1'b1;
      if (cnt == CNT_W'(K_SYM - 1)) begin
        busy  <= 1'b0;
        ready <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rs15_parity_chk.sv
module rs15_parity_chk #(
  parameter int K_SYM = 9,
  parameter int PAR_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             busy,
  input logic             ready,
  input logic [PAR_W-1:0] parity
);
  logic [7:0] bcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) bcnt <= '0;
    else        bcnt <= busy ? bcnt + 8'd1 : 8'd0;
  end

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !busy) |=> (busy && !ready));

  p_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && ready));

  p_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (bcnt == 8'(K_SYM)));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !en) |=> (ready && $stable(parity)));

  p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !en) |=> (!busy && !ready));
endmodule

bind rs15_parity_enc rs15_parity_chk #(.K_SYM(K_SYM), .PAR_W(NPAR*SYM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .busy(busy), .ready(ready), .parity(parity)
);

// File: tb/sim_rs15_parity_enc.sv
module sim_rs15_parity_enc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [31:0] msg_in = '0;
  logic        busy, ready;
  logic [23:0] parity;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rs15_parity_enc u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .msg_in(msg_in),
    .busy(busy), .ready(ready), .parity(parity)
  );

  localparam logic [31:0] VEC [8] = '{
    32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0001, 32'h8000_0000,
    32'h0002_401C, 32'h1234_5678, 32'hDEAD_BEEF, 32'h0F0F_0F0F
  };

  logic [3:0] exp_t [15];
  int         log_t [16];
  logic [3:0] gfull [7];

  function automatic logic [3:0] fmul(input logic [3:0] a, input logic [3:0] b);
    if (a == 0 || b == 0) return 4'h0;
    return exp_t[(log_t[a] + log_t[b]) % 15];
  endfunction

  function automatic logic [23:0] model(input logic [31:0] m);
    logic [3:0] cw [15];
    logic [3:0] q;
    for (int i = 0; i < 15; i++) cw[i] = 4'h0;
    for (int i = 0; i < 8; i++) cw[6 + i] = m[4*i +: 4];
    for (int d = 14; d >= 6; d--) begin
      q = cw[d];
      for (int j = 0; j < 7; j++) cw[d - 6 + j] = cw[d - 6 + j] ^ fmul(q, gfull[j]);
    end
    return {cw[5], cw[4], cw[3], cw[2], cw[1], cw[0]};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_word(input logic [31:0] m, input bit poke, output logic [23:0] p);
    int n;
    @(negedge clk);
    msg_in = m;
    en = 1'b1;
    @(negedge clk);
    check(busy && !ready, "R2 accept", {30'd0, busy, ready}, 32'h2);
    if (poke) msg_in = ~m;
    n = 0;
    while (busy && n < 50) begin
      n++;
      @(negedge clk);
      if (poke) msg_in = msg_in + 32'h1111_1111;
    end
    check(n == 9 && ready, "R3 busy length", n, 9);
    p = parity;
    en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(!busy && !ready && parity == 0, "R1 reset", {busy, ready, 6'd0, parity}, 32'h0);
    rst_n = 1'b1;
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [23:0] p, hold;
    logic [31:0] m;
    logic [3:0] v;
    v = 4'h1;
    for (int i = 0; i < 15; i++) begin
      exp_t[i] = v;
      log_t[v] = i;
      v = v[3] ? ((v << 1) ^ 4'h3) : (v << 1);
    end
    log_t[0] = 0;
    gfull[0] = 4'hC; gfull[1] = 4'hA; gfull[2] = 4'hC; gfull[3] = 4'h3;
    gfull[4] = 4'h9; gfull[5] = 4'h7; gfull[6] = 4'h1;

    do_reset();

    // R4 / R5: known codeword
    run_word(32'h0002_401C, 1'b0, p);
    check(p == 24'hC21CA6, "R4 R5 known vector", p, 24'hC21CA6);

    // R9: zero message
    run_word(32'h0, 1'b0, p);
    check(p == 24'h0, "R9 zero message", p, 24'h0);

    foreach (VEC[i]) begin
      run_word(VEC[i], 1'b0, p);
      check(p == model(VEC[i]), "R4 table", p, model(VEC[i]));
    end

    for (int i = 0; i < 40; i++) begin
      m = $urandom;
      run_word(m, 1'b0, p);
      check(p == model(m), "R4 random", p, model(m));
    end

    // R6: hold after ready while msg_in moves
    run_word(32'h1357_9BDF, 1'b0, hold);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      msg_in = $urandom;
    end
    check(ready && parity == hold, "R6 hold", {7'd0, ready, parity}, {8'h01, hold});

    // R8: msg_in toggles during busy
    run_word(32'hCAFE_0123, 1'b1, p);
    check(p == model(32'hCAFE_0123), "R8 input ignored while busy", p, model(32'hCAFE_0123));

    // R7: abandon after 3 busy cycles
    @(negedge clk);
    msg_in = 32'h5555_AAAA;
    en = 1'b1;
    repeat (3) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check(!busy && !ready, "R7 abandon", {30'd0, busy, ready}, 32'h0);
    run_word(32'h5555_AAAA, 1'b0, p);
    check(p == model(32'h5555_AAAA), "R7 next word after abandon", p, model(32'h5555_AAAA));

    // R1: reset in the middle of a word
    @(negedge clk);
    msg_in = 32'hFFFF_0000;
    en = 1'b1;
    repeat (4) @(negedge clk);
    do_reset();
    run_word(32'h0002_401C, 1'b0, p);
    check(p == 24'hC21CA6, "R1 R4 after mid-word reset", p, 24'hC21CA6);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule